// File: doc/BRIEF.md
# Latch-Framed Serial Configuration Port

This block is the configuration entry point of an audio converter datapath. A host shifts 16-bit words into it over three wires: a serial clock, a data line and a latch strobe. Bits are taken most significant first on each rising serial clock edge. When the latch strobe rises, the most recent 16 bits form a complete word. The two low bits of that word pick one of two configuration registers, and the rest of the word supplies that register's fields.

The serial clock has no fixed relation to the system clock. It may run without pause or arrive as a short burst. Shifting stops for as long as the latch is high. The rising edge of the latch passes through a flop synchronizer into the system clock domain and becomes a single-cycle load pulse. Because shifting is frozen while the latch is high, the captured word stays stable during that pulse.

The decoded fields come out as system-domain outputs. They select the input source, the serial data format, the word length, the bit-stream phase mode, the polarity of the silence flag and power-down. The host must change the latch only while the serial clock is low, and must hold the latch high for at least five system clock cycles.

Top module: `ctl_port`

## Requirements
- R1: The port samples the data line on every rising serial clock edge while the latch is low. A load uses only the last 16 bits sampled before the latch rose, with the first of those 16 bits becoming bit 15 of the word.
- R2: A register changes only when the latch rises. After the rise, the new value appears on the outputs within five system clock cycles. Shifting bits without a latch rise leaves every output unchanged, and each latch rise causes at most one load.
- R3: Word bits 1:0 give the target register: 00 selects register 0 and 01 selects register 1. A word carrying 10 or 11 changes no output.
- R4: Register 0 holds four fields. Bit 15 is power-down (`out_pwrdn`). Bits 13:12 are the input source (`out_src`: 00 PCM, 01 external filter, 10 DSD bit-stream). Bits 5:4 are the serial format (`out_fmt`: 00 I2S, 01 right-justified, 10 DSP, 11 left-justified). Bits 3:2 are the word length (`out_wlen`: 00 24-bit, 01 20-bit, 10 18-bit, 11 16-bit).
- R5: Register 1 holds two fields. Bit 6 is the bit-stream mode (`out_dsd_phase`: 0 normal, 1 phase modulation). Bit 8 is the silence flag polarity (`out_flag_pol`: 0 active high, 1 active low).
- R6: Serial clock edges that arrive while the latch is high do not disturb the captured word, so a free-running serial clock works the same as a 16-pulse burst.
- R7: Reset returns all fields to their defaults: not powered down, PCM source, I2S format, 24-bit words, normal bit-stream mode and an active-high flag. In terms of outputs, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| ctl_sclk | input | 1 | Serial control clock, asynchronous to `clk` |
| ctl_sdi | input | 1 | Serial control data, MSB first |
| ctl_latch | input | 1 | Latch strobe; its rising edge loads the word |
| out_pwrdn | output | 1 | Power-down request |
| out_src | output | 2 | Input source select |
| out_fmt | output | 2 | Serial audio format |
| out_wlen | output | 2 | Audio word length |
| out_dsd_phase | output | 1 | Bit-stream phase-modulation mode |
| out_flag_pol | output | 1 | Silence flag polarity |

## Verification
The hardest case to reach from the ports is a serial clock that keeps running across the latch pulse. In that case the word sits in the serial domain while the system domain is still synchronizing the latch, and any stray shift would corrupt the load. The stimulus covers it in two ways. Every second word is sent as a continuous stream: junk bits come before the word, the serial clock and the data line keep toggling throughout the latch-high window, and more junk follows it. Separate tests shift a full word with no latch, and apply reset in the middle of a run.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 2;

    // register selector codes in word bits 1:0
    localparam logic [ADDR_W-1:0] SEL_R0 = 2'b00;
    localparam logic [ADDR_W-1:0] SEL_R1 = 2'b01;

    // field positions
    localparam int POS_PWRDN = 15;
    localparam int POS_SRC   = 12;
    localparam int POS_FMT   = 4;
    localparam int POS_WLEN  = 2;
    localparam int POS_PHASE = 6;
    localparam int POS_POL   = 8;

    // field encodings
    localparam logic [1:0] SRC_PCM  = 2'b00;
    localparam logic [1:0] SRC_EXTF = 2'b01;
    localparam logic [1:0] SRC_DSD  = 2'b10;
    localparam logic [1:0] FMT_I2S  = 2'b00;
    localparam logic [1:0] FMT_RJ   = 2'b01;
    localparam logic [1:0] FMT_DSP  = 2'b10;
    localparam logic [1:0] FMT_LJ   = 2'b11;
    localparam logic [1:0] WL_24    = 2'b00;
    localparam logic [1:0] WL_20    = 2'b01;
    localparam logic [1:0] WL_18    = 2'b10;
    localparam logic [1:0] WL_16    = 2'b11;

    typedef struct packed {
        logic       pwrdn;
        logic [1:0] src;
        logic [1:0] fmt;
        logic [1:0] wlen;
    } r0_t;

    typedef struct packed {
        logic phase;
        logic pol;
    } r1_t;

    typedef struct packed {
        r0_t r0;
        r1_t r1;
    } regs_t;

    localparam r0_t R0_DEF = '{pwrdn: 1'b0, src: SRC_PCM, fmt: FMT_I2S, wlen: WL_24};
    localparam r1_t R1_DEF = '{phase: 1'b0, pol: 1'b0};

endpackage

// File: rtl/ctlp_shifter.sv
module ctlp_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic              latch,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
    } sh_t;

    sh_t s_d, s_q;

    // shift while the latch is low; freeze while it is high
    always_comb begin
        s_d = s_q;
        if (!latch) begin
            s_d.sh = {s_q.sh[WORD_W-2:0], sdi};
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o = s_q.sh;

    AST_FREEZE_ON_LATCH: assert property (@(posedge sclk) disable iff (!rst_n)
        latch |=> $stable(word_o)); // R6

    AST_SHIFT_IN: assert property (@(posedge sclk) disable iff (!rst_n)
        !latch |=> word_o[0] == $past(sdi)); // R1

endmodule

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sy_t;

    sy_t y_d, y_q;

    always_comb begin
        y_d       = y_q;
        y_d.chain = {y_q.chain[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) y_q <= '0;
        else        y_q <= y_d;
    end

    // rising edge seen after the last synchronizer stage
    assign rise_o = y_q.chain[STAGES-1] & ~y_q.chain[STAGES];

    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R2

endmodule

// File: rtl/ctlp_regs.sv
module ctlp_regs
    import ctlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output r0_t               r0_o,
    output r1_t               r1_o
);

    regs_t r_d, r_q;
    logic [ADDR_W-1:0] sel;
    logic unused_word_bits;

    assign sel = word_i[ADDR_W-1:0];
    assign unused_word_bits = ^{word_i[14], word_i[11:9], word_i[7]};

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            case (sel)
                SEL_R0: begin
                    r_d.r0.pwrdn = word_i[POS_PWRDN];
                    r_d.r0.src   = word_i[POS_SRC+:2];
                    r_d.r0.fmt   = word_i[POS_FMT+:2];
                    r_d.r0.wlen  = word_i[POS_WLEN+:2];
                end
                SEL_R1: begin
                    r_d.r1.phase = word_i[POS_PHASE];
                    r_d.r1.pol   = word_i[POS_POL];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.r0 <= R0_DEF;
            r_q.r1 <= R1_DEF;
        end else begin
            r_q <= r_d;
        end
    end

    assign r0_o = r_q.r0;
    assign r1_o = r_q.r1;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(r0_o) && $stable(r1_o)); // R2

    AST_R0_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && sel != SEL_R0) |=> $stable(r0_o)); // R3

    AST_R1_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && sel != SEL_R1) |=> $stable(r1_o)); // R3

    AST_R0_LOADS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && sel == SEL_R0) |=> (r0_o.pwrdn == $past(word_i[POS_PWRDN]))
                                   && (r0_o.wlen == $past(word_i[POS_WLEN+:2]))); // R4

    AST_R1_LOADS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && sel == SEL_R1) |=> (r1_o.phase == $past(word_i[POS_PHASE]))
                                   && (r1_o.pol == $past(word_i[POS_POL]))); // R5

endmodule

// File: rtl/ctl_port.sv
module ctl_port
    import ctlp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_sclk,
    input  logic       ctl_sdi,
    input  logic       ctl_latch,
    output logic       out_pwrdn,
    output logic [1:0] out_src,
    output logic [1:0] out_fmt,
    output logic [1:0] out_wlen,
    output logic       out_dsd_phase,
    output logic       out_flag_pol
);

    logic [WORD_W-1:0] word;
    logic              load;
    r0_t               r0;
    r1_t               r1;

    ctlp_shifter #(.WORD_W(WORD_W)) u_shift (
        .sclk   (ctl_sclk),
        .rst_n  (rst_n),
        .sdi    (ctl_sdi),
        .latch  (ctl_latch),
        .word_o (word)
    );

    ctlp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_latch),
        .rise_o  (load)
    );

    ctlp_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .word_i (word),
        .r0_o   (r0),
        .r1_o   (r1)
    );

    always_comb begin
        out_pwrdn     = r0.pwrdn;
        out_src       = r0.src;
        out_fmt       = r0.fmt;
        out_wlen      = r0.wlen;
        out_dsd_phase = r1.phase;
        out_flag_pol  = r1.pol;
    end

endmodule

// File: tb/tb_ctl_port.sv
`timescale 1ns/1ps
module tb_ctl_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_sclk = 1'b0;
    logic       ctl_sdi = 1'b0;
    logic       ctl_latch = 1'b0;
    logic       out_pwrdn;
    logic [1:0] out_src;
    logic [1:0] out_fmt;
    logic [1:0] out_wlen;
    logic       out_dsd_phase;
    logic       out_flag_pol;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    ctl_port dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_sclk      (ctl_sclk),
        .ctl_sdi       (ctl_sdi),
        .ctl_latch     (ctl_latch),
        .out_pwrdn     (out_pwrdn),
        .out_src       (out_src),
        .out_fmt       (out_fmt),
        .out_wlen      (out_wlen),
        .out_dsd_phase (out_dsd_phase),
        .out_flag_pol  (out_flag_pol)
    );

    // {word[15:0], expected outputs}; expected = {pwrdn, src, fmt, wlen, phase, pol}
    localparam int NVEC = 8;
    localparam logic [24:0] VEC [NVEC] = '{
        {16'h9038, 9'b1_01_11_10_0_0},
        {16'h0141, 9'b1_01_11_10_1_1},
        {16'hFFFE, 9'b1_01_11_10_1_1},
        {16'hFFFF, 9'b1_01_11_10_1_1},
        {16'h2014, 9'b0_10_01_01_1_1},
        {16'h0041, 9'b0_10_01_01_1_0},
        {16'h0101, 9'b0_10_01_01_0_1},
        {16'h000C, 9'b0_00_00_11_0_1}
    };

    function automatic logic [8:0] outs();
        return {out_pwrdn, out_src, out_fmt, out_wlen, out_dsd_phase, out_flag_pol};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ctl_sdi = bits[i];
            #3 ctl_sclk = 1'b1;
            #3 ctl_sclk = 1'b0;
        end
    endtask

    // latch pulse of 48 ns; with cont set the serial clock keeps toggling
    task automatic pulse_latch(input bit cont);
        ctl_latch = 1'b1;
        if (cont) begin
            for (int k = 0; k < 8; k++) begin
                ctl_sdi = k[0];
                #3 ctl_sclk = 1'b1;
                #3 ctl_sclk = 1'b0;
            end
        end else begin
            #48;
        end
        ctl_latch = 1'b0;
        if (cont) shift_bits(32'h5, 3);
        repeat (10) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_fields(input logic [8:0] e);
        chk("R4 power-down",   {15'd0, out_pwrdn},     {15'd0, e[8]});
        chk("R4 source",       {14'd0, out_src},       {14'd0, e[7:6]});
        chk("R4 format",       {14'd0, out_fmt},       {14'd0, e[5:4]});
        chk("R4 word length",  {14'd0, out_wlen},      {14'd0, e[3:2]});
        chk("R5 DSD phase",    {15'd0, out_dsd_phase}, {15'd0, e[1]});
        chk("R5 flag polarity",{15'd0, out_flag_pol},  {15'd0, e[0]});
    endtask

    initial begin : watchdog
        #400000;
        n_errors++;
        $display("FAIL R2 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        logic [8:0] last;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset defaults", {7'd0, outs()}, 16'd0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // table walk: even entries burst clock, odd entries continuous with junk prefix
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] w;
            logic [8:0]  e;
            bit          cont;
            string       tag;
            w    = VEC[i][24:9];
            e    = VEC[i][8:0];
            cont = i[0];
            if (cont) shift_bits({11'd0, 5'b10110, w}, 21);
            else      shift_bits({16'd0, w}, 16);
            pulse_latch(cont);
            if (w[1:0] >= 2'b10) tag = "R3 ignored selector";
            else if (cont)       tag = "R1 R6 last 16 bits, free-running clock";
            else                 tag = "R1 burst word";
            chk(tag, {7'd0, outs()}, {7'd0, e});
            chk_fields(e);
        end

        // R2: shifting without a latch changes nothing
        last = outs();
        shift_bits({16'd0, 16'hB03C}, 16);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R2 no latch no change", {7'd0, outs()}, {7'd0, last});

        // R7: reset in mid-run restores defaults
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 mid-run reset", {7'd0, outs()}, 16'd0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R6: free-running clock around the latch into register 1
        shift_bits({16'd0, 16'h0141}, 16);
        pulse_latch(1'b1);
        chk("R6 continuous clock load", {7'd0, outs()}, {7'd0, 9'b0_00_00_00_1_1});

        // R3: selector 11 after reset leaves defaults in register 0
        shift_bits({16'd0, 16'hB03F}, 16);
        pulse_latch(1'b0);
        chk("R3 selector 11 ignored", {7'd0, outs()}, {7'd0, 9'b0_00_00_00_1_1});

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule